// File: doc/BRIEF.md
# Packed vector AND-test mask unit

The block tests two packed integer vectors element by element. For each element it ANDs the matching elements of both sources and sets one bit of a 64-bit mask. That bit is 1 when the AND has any bit set. The controls choose the element width (8, 16, 32 or 64 bits) and the vector length (128, 256 or 512 bits). Together they fix how many mask bits are live.

An optional writemask zeroes individual result bits. Masked-off bits are forced to 0 and are never merged from an earlier value. For 32- and 64-bit elements, the second source can instead be a scalar taken from its lowest element and applied to every element. This happens only when it is flagged as broadcast and as coming from memory.

The result is registered once. The mask and a valid flag appear one clock edge after an accepted request. The block fits into an execution pipeline that decodes the operation elsewhere and writes the mask to its destination register downstream.

Top module: `vtm_unit`

## Requirements
- R1: With `elem_sz_i` encoded as 0=8, 1=16, 2=32 and 3=64 bits, mask bit j is 1 exactly when the AND of element j of both sources (element j occupies bits j*W upward) is non-zero, for every j below the element count.
- R2: With `vlen_i` encoded as 0=128, 1=256, 2=512 bits (3 acts as 512), the element count is the vector length divided by the element width. All mask bits from the element count up to bit 63 are 0.
- R3: When `mask_en_i` is 1, a result bit whose `wmask_i` bit is 0 is 0.
- R4: When `mask_en_i` is 0, `wmask_i` has no effect on the result.
- R5: For 32- and 64-bit elements with both `bcast_i` and `b_mem_i` set, the low 32 or 64 bits of `src_b_i` are ANDed with every element of `src_a_i`.
- R6: Broadcast is never applied for 8- and 16-bit elements, nor when `b_mem_i` is 0, even if `bcast_i` is set.
- R7: Source bits above the selected vector length do not affect the result.
- R8: A request with `in_valid_i` high produces `mask_o` and `out_valid_o` high at the next rising clock edge. A cycle without `in_valid_i` drops `out_valid_o` and holds `mask_o`.
- R9: Asserting `rst_ni` low clears `mask_o` and `out_valid_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request accepted this cycle |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector or broadcast scalar |
| wmask_i | input | 64 | Writemask, one bit per element |
| elem_sz_i | input | 2 | Element width select |
| vlen_i | input | 2 | Vector length select |
| mask_en_i | input | 1 | Apply writemask with zeroing |
| bcast_i | input | 1 | Broadcast flag for the second source |
| b_mem_i | input | 1 | Second source comes from memory |
| out_valid_o | output | 1 | Result valid |
| mask_o | output | 64 | Result mask |

## Verification
All-ones operands on every size and length combination expose the element count and the clearing of high bits directly. All-zero operands show that no bit is set without a common set bit. Random operands compared against a behavioural loop separate per-element AND detection from whole-vector detection and catch slicing errors. A scalar with only its low bit set tells true broadcast from element-wise use across all four widths and both memory settings. Sources with data only above the vector length show that those bits are ignored.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
  localparam int VEC_W  = 512;
  localparam int MASK_W = 64;
  localparam int CNT_W  = $clog2(MASK_W) + 1;

  typedef enum logic [1:0] {ESZ_8 = 2'd0, ESZ_16 = 2'd1, ESZ_32 = 2'd2, ESZ_64 = 2'd3} esz_e;
  typedef enum logic [1:0] {VL_128 = 2'd0, VL_256 = 2'd1, VL_512 = 2'd2, VL_FULL = 2'd3} vlen_e;

  // live element count: bytes in the selected length, scaled down by element width
  function automatic logic [CNT_W-1:0] elem_count(logic [1:0] sz, logic [1:0] vl);
    logic [CNT_W-1:0] bytes;
    case (vl)
      VL_128:  bytes = CNT_W'(MASK_W / 4);
      VL_256:  bytes = CNT_W'(MASK_W / 2);
      default: bytes = CNT_W'(MASK_W);
    endcase
    return bytes >> sz;
  endfunction
endpackage

// File: rtl/vtm_bcast_sel.sv
module vtm_bcast_sel #(
  parameter int VEC_W = vtm_pkg::VEC_W
) (
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [1:0]       elem_sz_i,
  input  logic             bcast_i,
  input  logic             b_mem_i,
  output logic [VEC_W-1:0] b_eff_o
);
  import vtm_pkg::*;
  localparam int REP32 = VEC_W / 32;
  localparam int REP64 = VEC_W / 64;

  logic [VEC_W-1:0] rep32, rep64;
  logic             do_bc;

  assign rep32 = {REP32{src_b_i[31:0]}};
  assign rep64 = {REP64{src_b_i[63:0]}};
  assign do_bc = bcast_i & b_mem_i;

  always_comb begin
    b_eff_o = src_b_i;
    if (do_bc) begin
      case (esz_e'(elem_sz_i))
        ESZ_32:  b_eff_o = rep32;
        ESZ_64:  b_eff_o = rep64;
        default: b_eff_o = src_b_i;
      endcase
    end
  end
endmodule

// File: rtl/vtm_lane_test.sv
module vtm_lane_test #(
  parameter int VEC_W  = vtm_pkg::VEC_W,
  parameter int MASK_W = vtm_pkg::MASK_W
) (
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  input  logic [1:0]        elem_sz_i,
  output logic [MASK_W-1:0] hit_o
);
  localparam int NUM_SZ = 4;

  logic [VEC_W-1:0]  conj;
  logic [MASK_W-1:0] hit_sz [NUM_SZ];

  assign conj = src_a_i & src_b_i;

  for (genvar s = 0; s < NUM_SZ; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int NE = VEC_W / EW;
    for (genvar j = 0; j < NE; j++) begin : g_el
      assign hit_sz[s][j] = |conj[j*EW +: EW];
    end
    if (NE < MASK_W) begin : g_pad
      assign hit_sz[s][MASK_W-1:NE] = '0;
    end
  end

  assign hit_o = hit_sz[elem_sz_i];
endmodule

// File: rtl/vtm_active_mask.sv
module vtm_active_mask #(
  parameter int MASK_W = vtm_pkg::MASK_W
) (
  input  logic [1:0]        elem_sz_i,
  input  logic [1:0]        vlen_i,
  input  logic              mask_en_i,
  input  logic [MASK_W-1:0] wmask_i,
  output logic [MASK_W-1:0] keep_o
);
  import vtm_pkg::*;

  logic [CNT_W-1:0]  cnt;
  logic [MASK_W-1:0] thermo;

  assign cnt = elem_count(elem_sz_i, vlen_i);

  for (genvar j = 0; j < MASK_W; j++) begin : g_th
    assign thermo[j] = (CNT_W'(j) < cnt);
  end

  assign keep_o = thermo & (mask_en_i ? wmask_i : {MASK_W{1'b1}});
endmodule

// File: rtl/vtm_unit.sv
module vtm_unit #(
  parameter int VEC_W  = vtm_pkg::VEC_W,
  parameter int MASK_W = vtm_pkg::MASK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [VEC_W-1:0]  src_a_i,
  input  logic [VEC_W-1:0]  src_b_i,
  input  logic [MASK_W-1:0] wmask_i,
  input  logic [1:0]        elem_sz_i,
  input  logic [1:0]        vlen_i,
  input  logic              mask_en_i,
  input  logic              bcast_i,
  input  logic              b_mem_i,
  output logic              out_valid_o,
  output logic [MASK_W-1:0] mask_o
);
  logic [VEC_W-1:0]  b_eff;
  logic [MASK_W-1:0] hit, keep;
  logic [MASK_W-1:0] mask_q;
  logic              vld_q;

  vtm_bcast_sel #(.VEC_W(VEC_W)) u_bcast (
    .src_b_i  (src_b_i),
    .elem_sz_i(elem_sz_i),
    .bcast_i  (bcast_i),
    .b_mem_i  (b_mem_i),
    .b_eff_o  (b_eff)
  );

  vtm_lane_test #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_lane (
    .src_a_i  (src_a_i),
    .src_b_i  (b_eff),
    .elem_sz_i(elem_sz_i),
    .hit_o    (hit)
  );

  vtm_active_mask #(.MASK_W(MASK_W)) u_keep (
    .elem_sz_i(elem_sz_i),
    .vlen_i   (vlen_i),
    .mask_en_i(mask_en_i),
    .wmask_i  (wmask_i),
    .keep_o   (keep)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) mask_q <= hit & keep;
    end
  end

  assign mask_o      = mask_q;
  assign out_valid_o = vld_q;
endmodule

// File: rtl/vtm_unit_chk.sv
module vtm_unit_chk #(
  parameter int VEC_W  = vtm_pkg::VEC_W,
  parameter int MASK_W = vtm_pkg::MASK_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [VEC_W-1:0]  src_a_i,
  input logic [MASK_W-1:0] wmask_i,
  input logic [1:0]        elem_sz_i,
  input logic [1:0]        vlen_i,
  input logic              mask_en_i,
  input logic              out_valid_o,
  input logic [MASK_W-1:0] mask_o
);
  import vtm_pkg::*;

  function automatic logic [MASK_W-1:0] live_bits(logic [1:0] sz, logic [1:0] vl);
    logic [CNT_W-1:0] c;
    c = elem_count(sz, vl);
    return (c >= CNT_W'(MASK_W)) ? {MASK_W{1'b1}} : ((MASK_W'(1) << c) - MASK_W'(1));
  endfunction

  AST_HIGH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ((mask_o & ~live_bits($past(elem_sz_i), $past(vlen_i))) == '0)); // R2
  AST_ZERO_MASKING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mask_en_i) |=> ((mask_o & ~$past(wmask_i)) == '0)); // R3
  AST_ZERO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && src_a_i == '0) |=> (mask_o == '0)); // R1
  AST_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(mask_o))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (mask_o == '0 && !out_valid_o)); // R9
endmodule

bind vtm_unit vtm_unit_chk #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .src_a_i    (src_a_i),
  .wmask_i    (wmask_i),
  .elem_sz_i  (elem_sz_i),
  .vlen_i     (vlen_i),
  .mask_en_i  (mask_en_i),
  .out_valid_o(out_valid_o),
  .mask_o     (mask_o)
);

// File: tb/vtm_unit_bench.sv
module vtm_unit_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [511:0] src_a_i = '0, src_b_i = '0;
  logic [63:0]  wmask_i = '0;
  logic [1:0]   elem_sz_i = '0, vlen_i = '0;
  logic         mask_en_i = 1'b0, bcast_i = 1'b0, b_mem_i = 1'b0;
  logic         out_valid_o;
  logic [63:0]  mask_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  vtm_unit u_vtm_unit (.*);

  typedef struct packed {
    logic [1:0] sz; logic [1:0] vl; logic men; logic bc; logic mem; logic [1:0] kind;
  } vec_t;

  // kind: 0 zero operands, 1 all ones, 2 random
  localparam vec_t TBL [24] = '{
    '{2'd0,2'd0,1'b0,1'b0,1'b0,2'd1}, '{2'd0,2'd1,1'b0,1'b0,1'b0,2'd1}, '{2'd0,2'd2,1'b0,1'b0,1'b0,2'd1},
    '{2'd1,2'd0,1'b0,1'b0,1'b0,2'd1}, '{2'd1,2'd1,1'b0,1'b0,1'b0,2'd1}, '{2'd1,2'd2,1'b0,1'b0,1'b0,2'd1},
    '{2'd2,2'd0,1'b0,1'b0,1'b0,2'd1}, '{2'd2,2'd1,1'b0,1'b0,1'b0,2'd1}, '{2'd2,2'd2,1'b0,1'b0,1'b0,2'd1},
    '{2'd3,2'd0,1'b0,1'b0,1'b0,2'd1}, '{2'd3,2'd1,1'b0,1'b0,1'b0,2'd1}, '{2'd3,2'd2,1'b0,1'b0,1'b0,2'd1},
    '{2'd0,2'd2,1'b1,1'b0,1'b0,2'd0}, '{2'd3,2'd2,1'b0,1'b1,1'b1,2'd0},
    '{2'd0,2'd2,1'b1,1'b1,1'b1,2'd2}, '{2'd1,2'd1,1'b1,1'b1,1'b1,2'd2},
    '{2'd2,2'd2,1'b1,1'b1,1'b1,2'd2}, '{2'd3,2'd2,1'b1,1'b1,1'b1,2'd2},
    '{2'd2,2'd0,1'b0,1'b1,1'b0,2'd2}, '{2'd3,2'd1,1'b1,1'b1,1'b0,2'd2},
    '{2'd1,2'd3,1'b0,1'b0,1'b0,2'd1}, '{2'd0,2'd3,1'b1,1'b0,1'b0,2'd2},
    '{2'd2,2'd1,1'b1,1'b0,1'b0,2'd2}, '{2'd3,2'd0,1'b1,1'b0,1'b0,2'd2}
  };

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [63:0] ref_mask(logic [511:0] a, logic [511:0] b, logic [63:0] w,
                                           logic [1:0] sz, logic [1:0] vl, logic men, logic bc, logic mem);
    int eb, vb, cnt;
    logic [511:0] em, ae, be;
    logic [63:0] r;
    eb = 8 << sz;
    vb = (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512;
    cnt = vb / eb;
    em = (512'(1) << eb) - 512'(1);
    r = '0;
    for (int j = 0; j < cnt; j++) begin
      ae = (a >> (j * eb)) & em;
      be = (bc && mem && sz >= 2'd2) ? (b & em) : ((b >> (j * eb)) & em);
      r[j] = ((ae & be) != '0) && (!men || w[j]);
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on falling edge, result captured at next rising edge, sampled at the falling edge after
  task automatic run(string req, logic [511:0] a, logic [511:0] b, logic [63:0] w,
                     logic [1:0] sz, logic [1:0] vl, logic men, logic bc, logic mem, logic [63:0] exp);
    @(negedge clk_i);
    src_a_i = a; src_b_i = b; wmask_i = w; elem_sz_i = sz; vlen_i = vl;
    mask_en_i = men; bcast_i = bc; b_mem_i = mem; in_valid_i = 1'b1;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    check(req, mask_o, exp);
    check("R8", {63'd0, out_valid_o}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [511:0] a, b, ones, lo1;
    logic [63:0]  w;
    ones = '1;
    lo1  = 512'd1;
    repeat (2) @(negedge clk_i);
    check("R9", mask_o, 64'd0);
    check("R9", {63'd0, out_valid_o}, 64'd0);
    rst_ni = 1'b1;

    foreach (TBL[i]) begin
      a = (TBL[i].kind == 2'd0) ? '0 : (TBL[i].kind == 2'd1) ? ones : rnd512();
      b = (TBL[i].kind == 2'd0) ? '0 : (TBL[i].kind == 2'd1) ? ones : rnd512();
      w = {$urandom, $urandom};
      run("R1", a, b, w, TBL[i].sz, TBL[i].vl, TBL[i].men, TBL[i].bc, TBL[i].mem,
          ref_mask(a, b, w, TBL[i].sz, TBL[i].vl, TBL[i].men, TBL[i].bc, TBL[i].mem));
    end

    for (int n = 0; n < 300; n++) begin
      logic [1:0] sz, vl;
      logic men, bc, mem;
      a = rnd512(); b = rnd512();
      // sparse operands so that both hit and miss elements occur
      for (int k = 0; k < 8; k++) begin
        a = a & rnd512(); b = b & rnd512();
      end
      w = {$urandom, $urandom};
      sz = 2'($urandom); vl = 2'($urandom);
      men = 1'($urandom); bc = 1'($urandom); mem = 1'($urandom);
      run("R1", a, b, w, sz, vl, men, bc, mem, ref_mask(a, b, w, sz, vl, men, bc, mem));
    end

    run("R2", ones, ones, '0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_FFFF);
    run("R2", ones, ones, '0, 2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFF);
    run("R2", ones, ones, '0, 2'd3, 2'd2, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_00FF);
    run("R2", ones, ones, '0, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFF);
    run("R3", ones, ones, 64'hF0F0_A5A5_0F0F_3C3C, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 64'hF0F0_A5A5_0F0F_3C3C);
    run("R3", ones, ones, 64'hFFFF_FFFF_FFFF_FFF6, 2'd2, 2'd1, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_00F6);
    run("R4", ones, ones, 64'd0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R5", ones, lo1, '0, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_FFFF);
    run("R5", ones, lo1, '0, 2'd3, 2'd2, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_00FF);
    run("R5", {16{32'h0000_0001, 32'h0}}, lo1, '0, 2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 64'h0000_0000_0000_AAAA);
    run("R6", ones, lo1, '0, 2'd0, 2'd2, 1'b0, 1'b1, 1'b1, 64'd1);
    run("R6", ones, lo1, '0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b1, 64'd1);
    run("R6", ones, lo1, '0, 2'd2, 2'd2, 1'b0, 1'b1, 1'b0, 64'd1);
    run("R7", {ones[511:128], 128'd0}, ones, '0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 64'd0);
    run("R7", ones, {ones[511:256], 256'd0}, '0, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 64'd0);

    // R8: idle cycle with changed inputs holds the mask and drops valid
    run("R8", ones, ones, '0, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 64'h3);
    src_a_i = '0; elem_sz_i = 2'd0; vlen_i = 2'd2;
    @(negedge clk_i);
    check("R8", mask_o, 64'h3);
    check("R8", {63'd0, out_valid_o}, 64'd0);

    // R9: asynchronous reset clears a live result
    run("R9", ones, ones, '0, 2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    #1 rst_ni = 1'b0;
    #1 check("R9", mask_o, 64'd0);
    check("R9", {63'd0, out_valid_o}, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule